// File: doc/BRIEF.md
# SOVA Reliability Measure Pipeline

This block computes the soft reliability of one decoded bit in a windowed soft-output Viterbi decoder. For every decoded bit it takes the hard decision together with one agreement flag and one path-metric difference per traceback depth. All of these belong to the most likely state and are already selected upstream. The agreement flag for a depth tells whether the survivor path and its competitor took the same decision at that depth. The survivor unit and the add-compare-select array sit outside the block.

The reliability starts at the largest value the reliability width can hold. It then passes through a chain of L registered compare-and-select stages, where stage k handles depth k. An agreeing depth passes the reliability through untouched. A disagreeing depth replaces it with the smaller of itself and that depth's metric difference. Each depth's flag and difference are skewed by k cycles inside the block, so a new bit can enter every cycle. The final stage drives an unsigned reliability and a signed soft value whose sign follows the hard decision.

The stage register has three enumerated select outcomes: SEL_IDLE, SEL_PREV and SEL_METRIC.
- SEL_IDLE: no valid data; the register holds its value.
- SEL_PREV: the incoming reliability is kept. This happens on agreement, or when the metric difference is not smaller.
- SEL_METRIC: the metric difference replaces the reliability.

The outcome is chosen again every cycle; no outcome carries over to the next cycle.

Top module: `sova_rel_pipe`

## Requirements
- R1: While rst_n is low and after its release with no input, out_valid, out_dec, out_rel and out_soft are all 0.
- R2: A bit presented with in_valid high at a rising edge appears with out_valid high exactly L rising edges later (L = 8 by default), and out_valid is low in the cycle before; out_dec equals the in_dec of that bit.
- R3: The reliability chain starts at 2^W-1 (63 for W = 6), so a bit whose in_agree bits are all 1 leaves with out_rel = 63.
- R4: A depth k whose agreement bit in_agree[k] is 1 leaves the reliability unchanged, whatever its metric difference in_delta[6k+5:6k].
- R5: A depth k with in_agree[k] = 0 sets the reliability to the smaller of in_delta[6k+5:6k] and the value reaching it from depths below k.
- R6: The final out_rel equals the minimum metric difference over all disagreeing depths, capped at 63; a difference of 0 yields 0 and a difference of 63 yields 63.
- R7: out_soft is a 7-bit two's complement value equal to +out_rel when out_dec is 0 and to -out_rel when out_dec is 1.
- R8: In every cycle where out_valid is low, out_dec, out_rel and out_soft are 0.
- R9: Bits presented on consecutive cycles are processed independently and leave on consecutive cycles in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new bit is presented |
| in_dec | input | 1 | Hard decision of the bit |
| in_agree | input | L | Bit k is 1 when the competing decisions agree at depth k |
| in_delta | input | L*W | Metric difference of depth k in bits [W*k+W-1:W*k], unsigned |
| out_valid | output | 1 | Result present |
| out_dec | output | 1 | Hard decision of the result |
| out_rel | output | W | Final unsigned reliability |
| out_soft | output | W+1 | Signed soft value, negated for decision 1 |

## Verification
Every cycle, the stage assertions check the per-stage update laws. An agreeing stage forwards its input exactly, and no stage ever raises the reliability. A disagreeing stage never exceeds its metric difference, and a zero difference forces zero. Behaviours that involve the whole chain can only be shown by the bench's directed scenarios. These are the exact L-cycle latency, the depth-to-bit alignment of the skewed side inputs, the minimum across several depths, the sign of the soft output and the ordering of back-to-back bits.

// File: rtl/sova_rel_pkg.sv
package sova_rel_pkg;

    // Outcome of one compare-and-select stage
    typedef enum logic [1:0] {
        SEL_IDLE   = 2'd0,
        SEL_PREV   = 2'd1,
        SEL_METRIC = 2'd2
    } rel_sel_e;

endpackage

// File: rtl/sova_rel_skew.sv
module sova_rel_skew #(
    parameter int W   = 7,
    parameter int DLY = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);
    generate
        if (DLY == 0) begin : g_pass
            assign d_o = d_i;
        end else begin : g_chain
            logic [W-1:0] taps [DLY];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DLY; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= d_i;
                    for (int i = 1; i < DLY; i++) taps[i] <= taps[i-1];
                end
            end
            assign d_o = taps[DLY-1];
        end
    endgenerate
endmodule

// File: rtl/sova_rel_stage.sv
module sova_rel_stage
    import sova_rel_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    input  logic         dec_i,
    input  logic [W-1:0] rel_i,
    input  logic         agree_i,
    input  logic [W-1:0] delta_i,
    output logic         v_o,
    output logic         dec_o,
    output logic [W-1:0] rel_o
);
    rel_sel_e     sel;
    logic [W-1:0] rel_nxt;

    always_comb begin
        if (!v_i)                sel = SEL_IDLE;
        else if (agree_i)        sel = SEL_PREV;
        else if (delta_i < rel_i) sel = SEL_METRIC;
        else                     sel = SEL_PREV;
    end

    always_comb begin
        unique case (sel)
            SEL_IDLE:   rel_nxt = rel_o;
            SEL_PREV:   rel_nxt = rel_i;
            SEL_METRIC: rel_nxt = delta_i;
            default:    rel_nxt = rel_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            dec_o <= 1'b0;
            rel_o <= '0;
        end else begin
            v_o   <= v_i;
            dec_o <= v_i ? dec_i : dec_o;
            rel_o <= rel_nxt;
        end
    end

    // R4: an agreeing depth forwards the incoming reliability unchanged
    p_agree_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && agree_i) |=> (rel_o == $past(rel_i)));

    // R5: no stage ever raises the reliability
    p_never_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> (rel_o <= $past(rel_i)));

    // R5: a disagreeing depth bounds the result by its metric difference
    p_metric_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && !agree_i) |=> (rel_o <= $past(delta_i)));

    // R6: a zero difference on a disagreeing depth forces zero
    p_zero_metric_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && !agree_i && (delta_i == '0)) |=> (rel_o == '0));
endmodule

// File: rtl/sova_rel_fmt.sv
module sova_rel_fmt #(
    parameter int W = 6
) (
    input  logic         v_i,
    input  logic         dec_i,
    input  logic [W-1:0] rel_i,
    output logic         out_valid,
    output logic         out_dec,
    output logic [W-1:0] out_rel,
    output logic [W:0]   out_soft
);
    logic [W:0] mag;
    logic [W:0] neg;

    always_comb begin
        mag       = {1'b0, rel_i};
        neg       = (~mag) + {{W{1'b0}}, 1'b1};
        out_valid = v_i;
        out_dec   = v_i & dec_i;
        out_rel   = v_i ? rel_i : '0;
        if (!v_i)       out_soft = '0;
        else if (dec_i) out_soft = neg;
        else            out_soft = mag;
    end

    // R8: idle outputs stay at zero
    always_comb begin
        if (!out_valid) begin
            a_idle_zero_r8: assert (out_soft == '0 && out_rel == '0);
        end
    end
endmodule

// File: rtl/sova_rel_pipe.sv
module sova_rel_pipe #(
    parameter int L = 8,
    parameter int W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_dec,
    input  logic [L-1:0]   in_agree,
    input  logic [L*W-1:0] in_delta,
    output logic           out_valid,
    output logic           out_dec,
    output logic [W-1:0]   out_rel,
    output logic [W:0]     out_soft
);
    localparam logic [W-1:0] REL_MAX = {W{1'b1}};
    localparam int           SIDE_W  = W + 1;

    logic         v_s   [L];
    logic         dec_s [L];
    logic [W-1:0] rel_s [L];

    generate
        for (genvar k = 0; k < L; k++) begin : g_depth
            logic [SIDE_W-1:0] side_raw;
            logic [SIDE_W-1:0] side_dly;
            logic              v_in;
            logic              dec_in;
            logic [W-1:0]      rel_in;

            assign side_raw = {in_agree[k], in_delta[W*k +: W]};

            sova_rel_skew #(.W(SIDE_W), .DLY(k)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (side_raw),
                .d_o   (side_dly)
            );

            if (k == 0) begin : g_head
                assign v_in   = in_valid;
                assign dec_in = in_dec;
                assign rel_in = REL_MAX;
            end else begin : g_link
                assign v_in   = v_s[k-1];
                assign dec_in = dec_s[k-1];
                assign rel_in = rel_s[k-1];
            end

            sova_rel_stage #(.W(W)) u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .v_i     (v_in),
                .dec_i   (dec_in),
                .rel_i   (rel_in),
                .agree_i (side_dly[SIDE_W-1]),
                .delta_i (side_dly[W-1:0]),
                .v_o     (v_s[k]),
                .dec_o   (dec_s[k]),
                .rel_o   (rel_s[k])
            );
        end
    endgenerate

    sova_rel_fmt #(.W(W)) u_fmt (
        .v_i       (v_s[L-1]),
        .dec_i     (dec_s[L-1]),
        .rel_i     (rel_s[L-1]),
        .out_valid (out_valid),
        .out_dec   (out_dec),
        .out_rel   (out_rel),
        .out_soft  (out_soft)
    );
endmodule

// File: tb/sova_rel_pipe_tb.sv
module sova_rel_pipe_tb;
    localparam int L = 8;
    localparam int W = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_dec = 1'b0;
    logic [L-1:0]   in_agree = '1;
    logic [L*W-1:0] in_delta = '0;
    logic           out_valid;
    logic           out_dec;
    logic [W-1:0]   out_rel;
    logic [W:0]     out_soft;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sova_rel_pipe #(.L(L), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dec(in_dec),
        .in_agree(in_agree), .in_delta(in_delta), .out_valid(out_valid),
        .out_dec(out_dec), .out_rel(out_rel), .out_soft(out_soft)
    );

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic int model_rel(logic [L-1:0] ag, logic [L*W-1:0] dl);
        int r = 63;
        for (int k = 0; k < L; k++)
            if (!ag[k] && int'(dl[W*k +: W]) < r) r = int'(dl[W*k +: W]);
        return r;
    endfunction

    function automatic int model_soft(int r, logic d);
        logic [W:0] s;
        s = d ? W'(0) - (W+1)'(r) : (W+1)'(r);
        return int'(s);
    endfunction

    task automatic check_out(string req, logic [L-1:0] ag, logic [L*W-1:0] dl, logic d);
        int r = model_rel(ag, dl);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " rel"},   int'(out_rel), r);
        chk({req, " dec"},   int'(out_dec), int'(d));
        chk({req, " soft"},  int'(out_soft), model_soft(r, d));
    endtask

    // one bit in, exact latency, then idle zero after
    task automatic run_one(string req, logic [L-1:0] ag, logic [L*W-1:0] dl, logic d);
        @(negedge clk);
        in_valid = 1'b1; in_agree = ag; in_delta = dl; in_dec = d;
        @(negedge clk);
        in_valid = 1'b0; in_agree = '1; in_delta = '0; in_dec = 1'b0;
        repeat (L-2) @(negedge clk);
        chk({req, " R2 no early valid"}, int'(out_valid), 0);
        @(negedge clk);
        check_out(req, ag, dl, d);
        @(negedge clk);
        chk({req, " R8 idle valid"}, int'(out_valid), 0);
        chk({req, " R8 idle rel"},   int'(out_rel), 0);
        chk({req, " R8 idle soft"},  int'(out_soft), 0);
        chk({req, " R8 idle dec"},   int'(out_dec), 0);
    endtask

    function automatic logic [L*W-1:0] put(logic [L*W-1:0] v, int k, int x);
        logic [L*W-1:0] t = v;
        t[W*k +: W] = W'(x);
        return t;
    endfunction

    task automatic t_reset_r1();
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset rel",   int'(out_rel), 0);
        rst_n = 1'b1;
        repeat (L+2) @(negedge clk);
        chk("R1 post valid", int'(out_valid), 0);
        chk("R1 post soft",  int'(out_soft), 0);
        chk("R1 post dec",   int'(out_dec), 0);
    endtask

    task automatic t_all_agree_r3();
        logic [L*W-1:0] dl = '0;
        for (int k = 0; k < L; k++) dl = put(dl, k, 5 + k);
        run_one("R3 all agree", '1, dl, 1'b0);
    endtask

    task automatic t_agree_ignored_r4();
        logic [L*W-1:0] dl = put('0, 3, 1);
        dl = put(dl, 6, 33);
        run_one("R4 agree ignores delta", 8'b1011_1111, dl, 1'b0);
    endtask

    task automatic t_single_r5();
        run_one("R5 single disagree", 8'b1111_1011, put('1, 2, 20), 1'b0);
    endtask

    task automatic t_min_r6();
        logic [L*W-1:0] dl = '1;
        dl = put(dl, 0, 30); dl = put(dl, 4, 12); dl = put(dl, 7, 45);
        run_one("R6 min of several", 8'b0110_1110, dl, 1'b0);
        run_one("R6 last depth only", 8'b0111_1111, put('1, 7, 9), 1'b0);
    endtask

    task automatic t_bounds_r6();
        run_one("R6 zero delta", 8'b1101_1111, put('1, 5, 0), 1'b0);
        run_one("R6 max delta", 8'b1111_1110, put('0, 0, 63), 1'b1);
    endtask

    task automatic t_sign_r7();
        run_one("R7 negative soft", 8'b1110_1111, put('1, 4, 17), 1'b1);
        run_one("R7 zero with dec 1", 8'b1111_0111, put('1, 3, 0), 1'b1);
    endtask

    task automatic t_burst_r9();
        logic [L-1:0]   ag [4];
        logic [L*W-1:0] dl [4];
        logic           dd [4];
        ag[0] = 8'b1111_1110; dl[0] = put('1, 0, 11); dd[0] = 1'b0;
        ag[1] = '1;           dl[1] = '0;             dd[1] = 1'b1;
        ag[2] = 8'b0000_0000; dl[2] = put('1, 6, 3);  dd[2] = 1'b1;
        ag[3] = 8'b1011_1101; dl[3] = put(put('1, 1, 50), 6, 40); dd[3] = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_agree = ag[i]; in_delta = dl[i]; in_dec = dd[i];
            @(negedge clk);
        end
        in_valid = 1'b0; in_agree = '1; in_delta = '0; in_dec = 1'b0;
        repeat (L-4) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check_out("R9 burst", ag[i], dl[i], dd[i]);
            @(negedge clk);
        end
        chk("R9 burst end valid", int'(out_valid), 0);
    endtask

    initial begin
        t_reset_r1();
        t_all_agree_r3();
        t_agree_ignored_r4();
        t_single_r5();
        t_min_r6();
        t_bounds_r6();
        t_sign_r7();
        t_burst_r9();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule